// File: doc/BRIEF.md
# Double-Buffered Interrupt Status Register

This block gathers event reports from a paging decoder into a status byte that a host reads over a register bus. Reading the byte acknowledges the interrupt. The interrupt line `irq_n` is active low. Events can arrive while the host has not yet read an earlier report, or while a read is still on the bus. Those events are parked in a secondary slot. When the read completes, the secondary slot moves into the primary register and the interrupt fires again one cycle later. A second call that reaches the secondary slot replaces the first one's status bits, so only the newest pending call survives.

The block also tracks whether the receiver is out of range. A live flag is set when the receiver enters fade recovery or carrier-off mode. It is cleared when a preamble or a valid sync word is found. The reported out-of-range bit takes the live value only when the receiver-enable input falls. Each change of the reported bit is an interrupt event of its own.

The status read is a plain level handshake, with no back-pressure. The bus holds `rd_busy` high for one or more cycles while it shifts the byte out. The first cycle in which `rd_busy` is sampled low after being high completes the read. While `rd_busy` is high, the event fields of the byte do not change.

Top module: `irq_status_dbuf`

## Requirements
- R1: After reset, `status_o` is 0x00 and `irq_n` is high.
- R2: Default field positions of the status byte are as follows. Bits 3:0 hold the call status bits. Bit 4 is the call flag. Bit 5 is the reported out-of-range level. Bit 6 is the range-change flag. Bit 7 is always 0. An event that arrives when the primary register holds no event, no read is in progress and no read completes on that edge loads the primary register on the next edge. `irq_n` goes low one edge after that.
- R3: An event that arrives while the primary register holds an unread event, or while `rd_busy` is high, goes to the secondary slot. The event fields of `status_o` stay unchanged.
- R4: When several calls are parked in the secondary slot, only the status bits of the last call are kept.
- R5: On the edge that completes a read, `irq_n` goes high and the primary register is loaded from the secondary slot, which is cleared. An event in that same cycle goes to the secondary slot if the slot had content. Otherwise it goes to the primary register.
- R6: If the transfer brought in an event, `irq_n` goes low again exactly one edge after it went high.
- R7: A completed read with an empty secondary slot clears bits 6 and 4:0, keeps bit 5, and leaves `irq_n` high until a new event arrives.
- R8: The live out-of-range flag is set by a fade-recovery or carrier-off entry strobe and cleared by a preamble or sync strobe. When set and clear strobes come in the same cycle, the clear wins.
- R9: Bit 5 of `status_o` changes only on an edge where `rx_en` is sampled low after being sampled high. On that edge it takes the live flag value.
- R10: An update that changes bit 5 raises an event with the range-change flag set. An update that leaves bit 5 unchanged raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_stb | input | 1 | One-cycle strobe: a call was received |
| call_bits | input | CALL_W | Status bits belonging to the call |
| preamble_stb | input | 1 | One-cycle strobe: preamble detected |
| sync_stb | input | 1 | One-cycle strobe: valid sync word detected |
| fade_stb | input | 1 | One-cycle strobe: fade recovery entered |
| carrier_off_stb | input | 1 | One-cycle strobe: carrier-off mode entered |
| rx_en | input | 1 | Receiver enable level |
| rd_busy | input | 1 | High while the bus reads the status byte |
| status_o | output | CALL_W+4 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A call into an empty register separates the direct-load path from the parking path. Calls during a read, and stacked calls behind an unread one, show whether routing honours both blocking conditions and whether the last call overwrites earlier ones. Reads with and without parked content separate the one-cycle re-interrupt from the plain clear. Receiver-disable edges with the reported bit changing and unchanged, together with a same-cycle set/clear strobe pair, show that out-of-range events are edge-gated, change-driven and clear-priority. A call landing on the completion edge exercises the handover between the two slots.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_PRI  = 2'd1,
    ROUTE_SEC  = 2'd2
  } route_e;

  // Decide where a new event lands in the current cycle.
  function automatic route_e pick_route(input logic evt,
                                        input logic done,
                                        input logic sec_pend,
                                        input logic busy,
                                        input logic pri_pend);
    route_e r;
    if (!evt)
      r = ROUTE_NONE;
    else if (done)
      r = sec_pend ? ROUTE_SEC : ROUTE_PRI;
    else if (busy || pri_pend)
      r = ROUTE_SEC;
    else
      r = ROUTE_PRI;
    return r;
  endfunction

endpackage

// File: rtl/isr_range_track.sv
module isr_range_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fade_stb,
  input  logic carrier_off_stb,
  input  logic preamble_stb,
  input  logic sync_stb,
  input  logic rx_en,
  output logic oor_flag,
  output logic oor_toggle
);

  logic live_q;
  logic live_nxt;
  logic rx_en_q;
  logic rx_fall;

  // R8: a clear strobe outranks a set strobe in the same cycle
  always_comb begin
    live_nxt = live_q;
    if (fade_stb || carrier_off_stb)
      live_nxt = 1'b1;
    if (preamble_stb || sync_stb)
      live_nxt = 1'b0;
  end

  assign rx_fall    = rx_en_q && !rx_en;
  // R10: only a real change of the reported level counts as an event
  assign oor_toggle = rx_fall && (live_nxt != oor_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      rx_en_q  <= 1'b0;
      oor_flag <= 1'b0;
    end else begin
      live_q  <= live_nxt;
      rx_en_q <= rx_en;
      if (rx_fall)
        oor_flag <= live_nxt;   // R9
    end
  end

endmodule

// File: rtl/isr_evt_slot.sv
module isr_evt_slot #(
  parameter int CALL_W = 4,
  localparam int EV_W  = CALL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [EV_W-1:0]   ld_val,
  input  logic              mrg,
  input  logic              mrg_call,
  input  logic [CALL_W-1:0] mrg_bits,
  input  logic              mrg_chg,
  output logic [EV_W-1:0]   q,
  output logic              pend
);

  // layout: {chg, call, bits}
  localparam int CALL_IX = CALL_W;
  localparam int CHG_IX  = CALL_W + 1;

  logic [EV_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr)
      nxt = '0;
    if (ld)
      nxt = ld_val;
    if (mrg) begin
      if (mrg_call) begin
        nxt[CALL_IX]      = 1'b1;
        nxt[CALL_W-1:0]   = mrg_bits;   // R4: newest call wins
      end
      if (mrg_chg)
        nxt[CHG_IX] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else
      q <= nxt;
  end

  assign pend = q[CALL_IX] || q[CHG_IX];

endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import irq_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_busy,
  input  logic   evt,
  input  logic   pri_pend,
  input  logic   sec_pend,
  output logic   rd_done,
  output route_e route,
  output logic   irq_n
);

  logic busy_q;

  assign rd_done = busy_q && !rd_busy;
  assign route   = pick_route(evt, rd_done, sec_pend, rd_busy, pri_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      busy_q <= rd_busy;
      // R5: completion edge releases the line; R6: it drops again next edge
      if (rd_done)
        irq_n <= 1'b1;
      else
        irq_n <= !pri_pend;
    end
  end

endmodule

// File: rtl/irq_status_dbuf.sv
module irq_status_dbuf
  import irq_stat_pkg::*;
#(
  parameter int CALL_W = 4,
  localparam int STAT_W = CALL_W + 4,
  localparam int EV_W   = CALL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_stb,
  input  logic [CALL_W-1:0] call_bits,
  input  logic              preamble_stb,
  input  logic              sync_stb,
  input  logic              fade_stb,
  input  logic              carrier_off_stb,
  input  logic              rx_en,
  input  logic              rd_busy,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_n
);

  logic            oor_flag;
  logic            oor_toggle;
  logic            evt;
  logic            rd_done;
  route_e          route;
  logic [EV_W-1:0] pri_q;
  logic [EV_W-1:0] sec_q;
  logic            pri_pend;
  logic            sec_pend;

  isr_range_track u_range (
    .clk             (clk),
    .rst_n           (rst_n),
    .fade_stb        (fade_stb),
    .carrier_off_stb (carrier_off_stb),
    .preamble_stb    (preamble_stb),
    .sync_stb        (sync_stb),
    .rx_en           (rx_en),
    .oor_flag        (oor_flag),
    .oor_toggle      (oor_toggle)
  );

  assign evt = call_stb || oor_toggle;

  isr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_busy  (rd_busy),
    .evt      (evt),
    .pri_pend (pri_pend),
    .sec_pend (sec_pend),
    .rd_done  (rd_done),
    .route    (route),
    .irq_n    (irq_n)
  );

  // primary: refilled from the secondary slot when a read completes
  isr_evt_slot #(.CALL_W(CALL_W)) u_pri (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (1'b0),
    .ld       (rd_done),
    .ld_val   (sec_q),
    .mrg      (route == ROUTE_PRI),
    .mrg_call (call_stb),
    .mrg_bits (call_bits),
    .mrg_chg  (oor_toggle),
    .q        (pri_q),
    .pend     (pri_pend)
  );

  // secondary: emptied on completion, collects parked events
  isr_evt_slot #(.CALL_W(CALL_W)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rd_done),
    .ld       (1'b0),
    .ld_val   ({EV_W{1'b0}}),
    .mrg      (route == ROUTE_SEC),
    .mrg_call (call_stb),
    .mrg_bits (call_bits),
    .mrg_chg  (oor_toggle),
    .q        (sec_q),
    .pend     (sec_pend)
  );

  assign status_o = {1'b0, pri_q[EV_W-1], oor_flag, pri_q[CALL_W:0]};

endmodule

// File: rtl/irq_status_dbuf_chk.sv
module irq_status_dbuf_chk #(
  parameter int CALL_W = 4,
  localparam int STAT_W = CALL_W + 4,
  localparam int EV_W   = CALL_W + 2,
  localparam int OOR_IX = CALL_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_busy,
  input logic              rx_en,
  input logic              irq_n,
  input logic [STAT_W-1:0] status_o,
  input logic [EV_W-1:0]   pri_q,
  input logic              sec_pend,
  input logic              rd_done
);

  p_frozen_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(pri_q));

  p_release_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_busy) && !rd_busy) |=> irq_n);

  p_reirq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && sec_pend) |=> irq_n ##1 !irq_n);

  p_oor_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(rx_en) && !rx_en) |=> $stable(status_o[OOR_IX]));

endmodule

bind irq_status_dbuf irq_status_dbuf_chk #(.CALL_W(CALL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_busy  (rd_busy),
  .rx_en    (rx_en),
  .irq_n    (irq_n),
  .status_o (status_o),
  .pri_q    (pri_q),
  .sec_pend (sec_pend),
  .rd_done  (rd_done)
);

// File: tb/irq_status_dbuf_test.sv
module irq_status_dbuf_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_stb = 1'b0;
  logic [3:0] call_bits = '0;
  logic       preamble_stb = 1'b0;
  logic       sync_stb = 1'b0;
  logic       fade_stb = 1'b0;
  logic       carrier_off_stb = 1'b0;
  logic       rx_en = 1'b1;
  logic       rd_busy = 1'b0;
  logic [7:0] status_o;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  logic done_flag = 1'b0;

  always #2 clk = ~clk;

  irq_status_dbuf uut (
    .clk(clk), .rst_n(rst_n), .call_stb(call_stb), .call_bits(call_bits),
    .preamble_stb(preamble_stb), .sync_stb(sync_stb), .fade_stb(fade_stb),
    .carrier_off_stb(carrier_off_stb), .rx_en(rx_en), .rd_busy(rd_busy),
    .status_o(status_o), .irq_n(irq_n)
  );

  // {req[3:0], call, bits[3:0], pre, sync, fade, coff, rxen, busy, stat[7:0], irq}
  function automatic logic [23:0] mk(input int r, input logic c, input logic [3:0] b,
                                     input logic pr, input logic sy, input logic fa,
                                     input logic co, input logic rx, input logic bz,
                                     input logic [7:0] st, input logic iq);
    logic [3:0] rr;
    rr = r[3:0];
    return {rr, c, b, pr, sy, fa, co, rx, bz, st, iq};
  endfunction

  localparam int NV = 39;
  localparam logic [23:0] VEC [NV] = '{
    mk(1, 0,4'h0, 0,0,0,0,1,0, 8'h00,1),  // R1 idle after reset
    mk(2, 1,4'hA, 0,0,0,0,1,0, 8'h1A,1),  // R2 direct load
    mk(2, 0,4'h0, 0,0,0,0,1,0, 8'h1A,0),  // R2 irq next edge
    mk(3, 1,4'h3, 0,0,0,0,1,0, 8'h1A,0),  // R3 parked behind unread
    mk(4, 1,4'h5, 0,0,0,0,1,0, 8'h1A,0),  // R4 overwrite parked
    mk(3, 0,4'h0, 0,0,0,0,1,1, 8'h1A,0),  // R3 read starts
    mk(3, 1,4'h7, 0,0,0,0,1,1, 8'h1A,0),  // R3 call during read
    mk(5, 0,4'h0, 0,0,0,0,1,0, 8'h17,1),  // R5 transfer, last call kept
    mk(6, 0,4'h0, 0,0,0,0,1,0, 8'h17,0),  // R6 re-interrupt
    mk(5, 0,4'h0, 0,0,0,0,1,1, 8'h17,0),
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h00,1),  // R7 empty transfer clears
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h00,1),  // R7 stays quiet
    mk(8, 0,4'h0, 0,0,1,0,1,0, 8'h00,1),  // R8 fade sets live flag
    mk(9, 0,4'h0, 0,0,0,0,0,0, 8'h60,1),  // R9 update on disable
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h60,0),  // R10 change interrupts
    mk(8, 0,4'h0, 0,1,0,0,1,0, 8'h60,0),  // R8 sync clears live only
    mk(9, 0,4'h0, 0,0,0,0,1,1, 8'h60,0),
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h20,1),  // R7 bit 5 kept
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h40,1),  // R10 falling change
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h40,0),
    mk(8, 0,4'h0, 0,0,0,1,1,0, 8'h40,0),  // R8 carrier-off sets
    mk(3, 0,4'h0, 0,0,0,0,0,0, 8'h60,0),  // R3 change parked
    mk(3, 0,4'h0, 0,0,0,0,1,1, 8'h60,0),
    mk(5, 0,4'h0, 0,0,0,0,1,0, 8'h60,1),  // R5 parked chg moved
    mk(6, 0,4'h0, 0,0,0,0,1,0, 8'h60,0),  // R6
    mk(7, 0,4'h0, 0,0,0,0,1,1, 8'h60,0),
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h20,1),  // R7
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h20,1),  // R10 no change no event
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h20,1),
    mk(8, 0,4'h0, 1,0,1,0,1,0, 8'h20,1),  // R8 clear wins
    mk(8, 0,4'h0, 0,0,0,0,0,0, 8'h40,1),  // R8 live is 0
    mk(10,0,4'h0, 0,0,0,0,0,0, 8'h40,0),
    mk(7, 0,4'h0, 0,0,0,0,1,1, 8'h40,0),
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h00,1),
    mk(3, 1,4'h9, 0,0,0,0,1,1, 8'h00,1),  // R3 read with empty primary
    mk(5, 0,4'h0, 0,0,0,0,1,0, 8'h19,1),  // R5
    mk(6, 0,4'h0, 0,0,0,0,1,0, 8'h19,0),  // R6
    mk(7, 0,4'h0, 0,0,0,0,1,1, 8'h19,0),
    mk(7, 0,4'h0, 0,0,0,0,1,0, 8'h00,1)
  };

  task automatic chk(input int req, input logic [7:0] exp_st, input logic exp_iq);
    total++;
    if (status_o !== exp_st || irq_n !== exp_iq) begin
      bad++;
      $display("FAIL R%0d status=%02h irq_n=%b expected status=%02h irq_n=%b",
               req, status_o, irq_n, exp_st, exp_iq);
    end
  endtask

  task automatic step(input logic c, input logic [3:0] b, input logic bz);
    call_stb = c; call_bits = b; rd_busy = bz;
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, 8'h00, 1'b1);                  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      call_stb = v[19]; call_bits = v[18:15];
      preamble_stb = v[14]; sync_stb = v[13]; fade_stb = v[12];
      carrier_off_stb = v[11]; rx_en = v[10]; rd_busy = v[9];
      @(posedge clk); #1;
      chk(int'(v[23:20]), v[8:1], v[0]);
      @(negedge clk);
    end
    preamble_stb = 0; sync_stb = 0; fade_stb = 0; carrier_off_stb = 0; rx_en = 1;

    // R5 corner: call on the completion edge with empty secondary
    step(1, 4'h2, 0);
    step(0, 4'h0, 1);
    call_stb = 1; call_bits = 4'hC; rd_busy = 0;
    @(posedge clk); #1;
    chk(5, 8'h1C, 1'b1);
    @(negedge clk);
    call_stb = 0;
    @(posedge clk); #1;
    chk(2, 8'h1C, 1'b0);
    @(negedge clk);

    // R1: reset while an event is pending
    rst_n = 1'b0;
    #1;
    chk(1, 8'h00, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, 8'h00, 1'b1);

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule